// File: doc/BRIEF.md
# Byte-Sliced Ripple ALU

This block is a purely combinational arithmetic logic unit with a 16-bit datapath. It takes two operand words and a 3-bit operation code, and it returns a result word and a single carry flag. The result and the carry are separate outputs. No zero flag and no overflow flag are produced, and the block holds no state.

The datapath is a row of identical byte-wide slices. Each slice computes three things side by side: an arithmetic sum, a bitwise logic value and a one-bit shift. A per-slice multiplexer, steered by the opcode, picks one of the three. For add and subtract, the carry out of each slice feeds the carry in of the next slice, with no lookahead. The delay of the full word is therefore the sum of the slice delays. For shifts, the edge bit of each slice passes to the neighbouring slice.

The block is meant to sit in a simple datapath. A register file or a test harness presents operands and an opcode, and reads both outputs back after one settling interval.

Top module: `alu_chain16`

## Requirements
- R1: The outputs `res` and `cy` depend only on the current `opa`, `opb` and `sel`. The block holds no state, so every result is valid within the same cycle that its inputs change.
- R2: When `sel` = 3'b000 (add), `res` = (opa + opb) mod 65536 and `cy` = bit 16 of the sum. For example, opa = 7 and opb = 8 give `res` = 15 and `cy` = 0.
- R3: When `sel` = 3'b001 (subtract), `res` = opa + ~opb + 1 mod 65536. `cy` is the carry out of that sum, so `cy` = 1 exactly when opa >= opb (no borrow).
- R4: For add and subtract, the carry out of the low byte reaches the high byte. For example, 0x00FF + 0x0001 gives 0x0100 with `cy` = 0, and 0x0100 - 0x0001 gives 0x00FF with `cy` = 1.
- R5: When `sel` is 3'b010, 3'b011 or 3'b100, `res` is the bitwise AND, OR or XOR of the operands, respectively, and `cy` = 0.
- R6: When `sel` = 3'b111, `res` = ~opa and `cy` = 0, whatever value `opb` holds.
- R7: When `sel` = 3'b101, `res` = opa shifted left by one bit with a zero entering bit 0. Bit 7 moves into bit 8, and `cy` = opa[15].
- R8: When `sel` = 3'b110, `res` = opa shifted right by one bit with a zero entering bit 15. Bit 8 moves into bit 7, and `cy` = opa[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand; the only operand for shifts and NOT |
| opb | input | 16 | Second operand |
| sel | input | 3 | Operation code |
| res | output | 16 | Selected result word |
| cy | output | 1 | Carry flag: adder carry out, shifted-out bit, or 0 |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies anywhere between the inputs and the outputs. The bench drives the operands and the opcode on the rising edge. It compares `res` and `cy` with its behavioural model on the following falling edge, half a period later, after the ripple through both slices has settled. Directed patterns cover:
- zero and all-ones operands,
- the byte-boundary carry and borrow,
- the bit crossing between the two bytes on a shift,
- the 7 + 8 case.

Random operands then cover all eight opcodes.

// File: rtl/alu_chain16.sv
module alu_chain16 #(
  parameter int SLICE_W = 8,
  parameter int NSLICE  = 2
) (
  input  logic [SLICE_W*NSLICE-1:0] opa,
  input  logic [SLICE_W*NSLICE-1:0] opb,
  input  logic [2:0]                sel,
  output logic [SLICE_W*NSLICE-1:0] res,
  output logic                      cy
);
  localparam int W = SLICE_W * NSLICE;

  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_SUB = 3'b001;
  localparam logic [2:0] OP_AND = 3'b010;
  localparam logic [2:0] OP_OR  = 3'b011;
  localparam logic [2:0] OP_XOR = 3'b100;
  localparam logic [2:0] OP_SHL = 3'b101;
  localparam logic [2:0] OP_SHR = 3'b110;
  localparam logic [2:0] OP_NOT = 3'b111;

  logic is_sub;
  assign is_sub = (sel == OP_SUB);

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [SLICE_W-1:0] xa, xb, sum, lg, sh, r;
    logic ci, co, shl_in, shr_in;

    assign xa = opa[s*SLICE_W +: SLICE_W];
    assign xb = is_sub ? ~opb[s*SLICE_W +: SLICE_W] : opb[s*SLICE_W +: SLICE_W];

    if (s == 0) begin : g_first
      assign ci     = is_sub;
      assign shl_in = 1'b0;
    end else begin : g_link
      assign ci     = g_slice[s-1].co;
      assign shl_in = opa[s*SLICE_W-1];
    end

    if (s == NSLICE-1) begin : g_last
      assign shr_in = 1'b0;
    end else begin : g_next
      assign shr_in = opa[(s+1)*SLICE_W];
    end

    always_comb begin
      logic c;
      c = ci;
      for (int i = 0; i < SLICE_W; i++) begin
        sum[i] = xa[i] ^ xb[i] ^ c;
        c      = (xa[i] & xb[i]) | (c & (xa[i] ^ xb[i]));
      end
      co = c;
    end

    always_comb begin
      case (sel)
        OP_AND:  lg = xa & opb[s*SLICE_W +: SLICE_W];
        OP_OR:   lg = xa | opb[s*SLICE_W +: SLICE_W];
        OP_XOR:  lg = xa ^ opb[s*SLICE_W +: SLICE_W];
        default: lg = ~xa;
      endcase
    end

    assign sh = (sel == OP_SHL) ? {xa[SLICE_W-2:0], shl_in}
                                : {shr_in, xa[SLICE_W-1:1]};

    always_comb begin
      case (sel)
        OP_ADD, OP_SUB:                 r = sum;
        OP_AND, OP_OR, OP_XOR, OP_NOT:  r = lg;
        default:                        r = sh;
      endcase
    end

    assign res[s*SLICE_W +: SLICE_W] = r;
  end

  always_comb begin
    case (sel)
      OP_ADD, OP_SUB: cy = g_slice[NSLICE-1].co;
      OP_SHL:         cy = opa[W-1];
      OP_SHR:         cy = opa[0];
      default:        cy = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_chain16_chk.sv
module alu_chain16_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [2:0]   sel,
  input logic [W-1:0] res,
  input logic         cy
);
  logic [W:0] add_ref, sub_ref;
  assign add_ref = {1'b0, opa} + {1'b0, opb};
  assign sub_ref = {1'b0, opa} + {1'b0, ~opb} + {{W{1'b0}}, 1'b1};

  always_comb begin
    if (sel == 3'b000) AST_ADD_SUM: assert ({cy, res} == add_ref); // R2
    if (sel == 3'b001) AST_SUB_NO_BORROW: assert (cy == (opa >= opb) && res == sub_ref[W-1:0]); // R3
    if (sel == 3'b010 || sel == 3'b011 || sel == 3'b100) AST_LOGIC_CARRY_LOW: assert (!cy); // R5
    if (sel == 3'b111) AST_NOT_INVERTS: assert (res == ~opa && !cy); // R6
    if (sel == 3'b101) AST_SHL_OUT: assert (cy == opa[W-1] && res[0] == 1'b0); // R7
    if (sel == 3'b110) AST_SHR_OUT: assert (cy == opa[0] && res[W-1] == 1'b0); // R8
  end
endmodule

bind alu_chain16 alu_chain16_chk #(.W(SLICE_W*NSLICE)) u_chk (
  .opa(opa), .opb(opb), .sel(sel), .res(res), .cy(cy)
);

// File: tb/sim_alu_chain16.sv
module sim_alu_chain16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] opa = '0, opb = '0;
  logic [2:0]  sel = '0;
  logic [15:0] res;
  logic        cy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_chain16 u0 (.opa(opa), .opb(opb), .sel(sel), .res(res), .cy(cy));

  function automatic logic [16:0] model(input int a, input int b, input int op);
    int r;
    case (op)
      0: r = a + b;
      1: r = a + (b ^ 'hFFFF) + 1;
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = ((a << 1) & 'hFFFF) | (((a >> 15) & 1) << 16);
      6: r = (a >> 1) | ((a & 1) << 16);
      default: r = a ^ 'hFFFF;
    endcase
    return r[16:0];
  endfunction

  function automatic string tag(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R5";
      5: return "R7";
      6: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op, input string req);
    logic [16:0] exp;
    @(posedge clk);
    opa = a; opb = b; sel = op;
    exp = model(int'(a), int'(b), int'(op));
    @(negedge clk);
    checks++;
    if ({cy, res} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual res=%h cy=%b expected res=%h cy=%b",
               req, op, a, b, res, cy, exp[15:0], exp[16]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (res !== 16'h0 || cy !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle actual res=%h cy=%b expected res=0000 cy=0", res, cy);
    end
    apply(16'd7, 16'd8, 3'b000, "R2");
    apply(16'h00FF, 16'h0001, 3'b000, "R4");
    apply(16'hFFFF, 16'h0001, 3'b000, "R2");
    apply(16'h0100, 16'h0001, 3'b001, "R4");
    apply(16'h0005, 16'h0009, 3'b001, "R3");
    apply(16'h1234, 16'h1234, 3'b001, "R3");
    apply(16'h0000, 16'hFFFF, 3'b001, "R3");
    apply(16'hF0F0, 16'hFF00, 3'b010, "R5");
    apply(16'hF0F0, 16'h0F00, 3'b011, "R5");
    apply(16'hFFFF, 16'h5A5A, 3'b100, "R5");
    apply(16'h00FF, 16'h1234, 3'b111, "R6");
    apply(16'h00FF, 16'hFFFF, 3'b111, "R6");
    apply(16'h0080, 16'h0000, 3'b101, "R7");
    apply(16'h8001, 16'h0000, 3'b101, "R7");
    apply(16'h0100, 16'h0000, 3'b110, "R8");
    apply(16'h0001, 16'h0000, 3'b110, "R8");
    for (int op = 0; op < 8; op++) begin
      apply(16'h0000, 16'h0000, 3'(op), tag(op));
      apply(16'hFFFF, 16'hFFFF, 3'(op), tag(op));
    end
    for (int n = 0; n < 2000; n++) begin
      int op;
      op = int'($urandom_range(0, 7));
      apply(16'($urandom), 16'($urandom), 3'(op), tag(op));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule